// File: doc/BRIEF.md
# I2C Control-Register Target

This block is a byte-oriented I2C target that lets a host processor read and write a small bank of 8-bit control and status registers inside a radio tuner core. The raw SCL and SDA pins are brought into the system clock domain, cleaned by a short glitch filter and then decoded into start, stop, bit and acknowledge events. The target answers to the 7-bit address 60h: write bytes C0h, read bytes C1h.

A write transaction carries the device address, a register pointer and exactly one data byte. Only that first data byte is committed. Any further data bytes are acknowledged and thrown away, and the pointer does not advance. A read sets the pointer with a short write, then turns the bus around with a repeated start, or with a stop followed by a new start. One register byte is then returned, and the host closes it with NACK.

The writable registers are presented to the core as one flat vector. Three read-only locations show live status inputs. The identifier location returns a fixed code, and a write there raises a one-cycle abort strobe toward the command sequencer. Reading the two flag-bearing status locations raises one-cycle clear strobes once the byte has left the target.

Top module: `i2c_rf_slave`

## Requirements
- R1: While `rst_n` is low and on the first cycle after it, `ctrl_regs_o` is all zeros, `sda_oe_o` is 0 and the three strobes are 0.
- R2: The target pulls SDA low during the ninth SCL clock of an address byte C0h or C1h, and of every byte written after C0h.
- R3: The data byte of a write to a writable pointer appears in `ctrl_regs_o` at slot k, bits [8k+7:8k], with k = 0..9 for pointers 0Bh, 0Dh, 0Eh, 0Fh, 19h, 1Ah, 1Bh, 1Dh, 1Eh, 1Fh. Those bits change only when such a write is committed.
- R4: A read returns the pointed register MSB first. Each bit is placed on SDA after a falling SCL edge, and a writable register reads back its last written value.
- R5: Pointer 00h reads as 12h. A write to 00h stores nothing and gives exactly one single-cycle pulse on `abort_o`.
- R6: Pointers 02h, 10h and 11h read the current values of `radio_stat_i`, `tune_lo_i` and `tune_hi_i`. Writes to them change no register.
- R7: Once the eighth bit of a read of 02h has been clocked out, `clr_radio_irq_o` pulses high for one cycle. A read of 11h does the same on `clr_cmd_end_o`. Reads of any other pointer pulse neither strobe.
- R8: In a write, only the first data byte after the pointer is committed. Later bytes are acknowledged but written nowhere, including the next pointer.
- R9: If the address byte's upper seven bits are not 60h, there is no ACK. SDA stays released and nothing is written until the next start condition.
- R10: Unmapped pointers read as 00h, and writes to them change nothing.
- R11: The pointer set in the write phase is kept for the read phase, whether that phase follows a repeated start or a stop followed by a start.
- R12: A pulse on SCL or SDA that lasts fewer than `FILT_LEN` system clocks is ignored and does not disturb the transaction in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw SCL pin level |
| sda_i | input | 1 | Raw SDA pin level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| radio_stat_i | input | 8 | Live radio status, read at pointer 02h |
| tune_lo_i | input | 8 | Tune position low byte, read at pointer 10h |
| tune_hi_i | input | 8 | Tune position high byte and flags, read at pointer 11h |
| ctrl_regs_o | output | 80 | Writable registers, slot k at bits [8k+7:8k] |
| abort_o | output | 1 | One-cycle pulse on a write to pointer 00h |
| clr_radio_irq_o | output | 1 | One-cycle pulse after a read of 02h |
| clr_cmd_end_o | output | 1 | One-cycle pulse after a read of 11h |

## Verification
The bound checker watches properties that hold on every clock. The register vector moves only on a committed write, and never on a write to the identifier or read-only pointers. Each strobe lasts one cycle and traces back to the matching write or finished read, no two strobes coincide, and SDA stays released while a foreign address is being ignored. Other behaviour is visible only through whole transactions, so the bench's scenarios must show it: the ACK slots, the bit order of returned data, discarded trailing bytes, the pointer surviving both turnaround styles, unmapped reads of zero, and the rejection of short glitches.

// File: rtl/i2c_rf_pkg.sv
// Shared constants and types for the I2C control-register target.
// Assumes pointer values are 8 bits and the writable bank is at most 16 deep.
package i2c_rf_pkg;
    localparam int          NUM_RW   = 10;
    localparam int          CTRL_W   = NUM_RW * 8;
    localparam logic [7:0]  PTR_ID   = 8'h00;
    localparam logic [7:0]  PTR_RSTAT = 8'h02;
    localparam logic [7:0]  PTR_TPLO = 8'h10;
    localparam logic [7:0]  PTR_TPHI = 8'h11;

    typedef enum logic [2:0] {
        BS_IDLE,
        BS_RX,
        BS_RX_ACK,
        BS_TX,
        BS_TX_ACK,
        BS_SKIP
    } bus_state_t;

    typedef struct packed {
        logic       hit;
        logic [3:0] idx;
    } slot_t;

    // Map a pointer to its slot in the writable bank.
    function automatic slot_t rw_slot(input logic [7:0] ptr);
        slot_t s;
        s.hit = 1'b1;
        s.idx = 4'd0;
        case (ptr)
            8'h0B: s.idx = 4'd0;
            8'h0D: s.idx = 4'd1;
            8'h0E: s.idx = 4'd2;
            8'h0F: s.idx = 4'd3;
            8'h19: s.idx = 4'd4;
            8'h1A: s.idx = 4'd5;
            8'h1B: s.idx = 4'd6;
            8'h1D: s.idx = 4'd7;
            8'h1E: s.idx = 4'd8;
            8'h1F: s.idx = 4'd9;
            default: s.hit = 1'b0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/i2c_rf_glitch.sv
// Two-flop synchronizer followed by a persistence filter for one bus line.
// The output follows the input only after FILT_LEN consecutive differing samples.
// Assumes the idle bus level is high.
module i2c_rf_glitch #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] cnt_q;

    // Bring the asynchronous pin into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], din};
    end

    // Accept a new level only after it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            dout  <= 1'b1;
        end else if (sync_q[1] != dout) begin
            if (cnt_q == CW'(FILT_LEN - 1)) begin
                dout  <= sync_q[1];
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else begin
            cnt_q <= '0;
        end
    end
endmodule

// File: rtl/i2c_rf_bus.sv
// Bus engine: decodes start/stop, shifts bytes, drives ACK and read data.
// Assumes filtered SCL/SDA; SDA is only changed after a detected SCL fall.
// Emits a one-cycle write strobe for the first data byte and a read-done strobe.
module i2c_rf_bus
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl,
    input  logic       sda,
    input  logic [7:0] rd_data,
    output logic       sda_oe,
    output logic       wr_en,
    output logic [7:0] wr_data,
    output logic [7:0] ptr,
    output logic       rd_done,
    output logic       skip
);
    bus_state_t  state_q;
    logic        scl_d, sda_d;
    logic [3:0]  bit_cnt;
    logic [7:0]  shift_q;
    logic [1:0]  byte_no;
    logic        is_read;

    logic scl_rise, scl_fall, start_c, stop_c;

    assign scl_rise = scl & ~scl_d;
    assign scl_fall = ~scl & scl_d;
    assign start_c  = scl & scl_d & sda_d & ~sda;
    assign stop_c   = scl & scl_d & ~sda_d & sda;
    assign skip     = (state_q == BS_SKIP);

    // Keep the previous filtered levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl;
            sda_d <= sda;
        end
    end

    // Protocol sequencer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= BS_IDLE;
            bit_cnt <= '0;
            shift_q <= '0;
            byte_no <= '0;
            is_read <= 1'b0;
            ptr     <= '0;
            sda_oe  <= 1'b0;
            wr_en   <= 1'b0;
            wr_data <= '0;
            rd_done <= 1'b0;
        end else begin
            wr_en   <= 1'b0;
            rd_done <= 1'b0;
            if (start_c) begin
                state_q <= BS_RX;
                bit_cnt <= '0;
                byte_no <= '0;
                is_read <= 1'b0;
                sda_oe  <= 1'b0;
            end else if (stop_c) begin
                state_q <= BS_IDLE;
                sda_oe  <= 1'b0;
            end else begin
                case (state_q)
                    BS_RX: begin
                        if (scl_rise && bit_cnt != 4'd8) begin
                            shift_q <= {shift_q[6:0], sda};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (byte_no != 2'd3) byte_no <= byte_no + 1'b1;
                            case (byte_no)
                                2'd0: begin
                                    if (shift_q[7:1] == DEV_ADDR) begin
                                        is_read <= shift_q[0];
                                        sda_oe  <= 1'b1;
                                        state_q <= BS_RX_ACK;
                                    end else begin
                                        state_q <= BS_SKIP;
                                    end
                                end
                                2'd1: begin
                                    ptr     <= shift_q;
                                    sda_oe  <= 1'b1;
                                    state_q <= BS_RX_ACK;
                                end
                                2'd2: begin
                                    wr_en   <= 1'b1;
                                    wr_data <= shift_q;
                                    sda_oe  <= 1'b1;
                                    state_q <= BS_RX_ACK;
                                end
                                default: begin
                                    sda_oe  <= 1'b1;
                                    state_q <= BS_RX_ACK;
                                end
                            endcase
                        end
                    end
                    BS_RX_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (is_read) begin
                                shift_q <= rd_data;
                                sda_oe  <= ~rd_data[7];
                                state_q <= BS_TX;
                            end else begin
                                sda_oe  <= 1'b0;
                                state_q <= BS_RX;
                            end
                        end
                    end
                    BS_TX: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == 4'd8) begin
                                sda_oe  <= 1'b0;
                                rd_done <= 1'b1;
                                state_q <= BS_TX_ACK;
                            end else begin
                                shift_q <= {shift_q[6:0], 1'b0};
                                sda_oe  <= ~shift_q[6];
                            end
                        end
                    end
                    BS_TX_ACK: begin
                        if (scl_rise) state_q <= BS_SKIP;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_rf_regs.sv
// Register bank: writable slots, read mux, abort and clear-on-read strobes.
// Assumes wr_en and rd_done are single-cycle pulses from the bus engine.
module i2c_rf_regs
    import i2c_rf_pkg::*;
#(
    parameter logic [7:0] ID_VALUE = 8'h12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [7:0]        rd_addr,
    input  logic              rd_done,
    input  logic [7:0]        radio_stat,
    input  logic [7:0]        tune_lo,
    input  logic [7:0]        tune_hi,
    output logic [CTRL_W-1:0] ctrl,
    output logic [7:0]        rd_data,
    output logic              abort,
    output logic              clr_radio,
    output logic              clr_cmd
);
    slot_t wsl, rsl;
    assign wsl = rw_slot(wr_addr);
    assign rsl = rw_slot(rd_addr);

    // One storage byte per writable slot.
    for (genvar g = 0; g < NUM_RW; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)                                   ctrl[g*8 +: 8] <= 8'h00;
            else if (wr_en && wsl.hit && wsl.idx == 4'(g)) ctrl[g*8 +: 8] <= wr_data;
        end
    end

    // Select the byte returned for the current pointer.
    always_comb begin
        if (rsl.hit)                    rd_data = ctrl[rsl.idx*8 +: 8];
        else if (rd_addr == PTR_ID)     rd_data = ID_VALUE;
        else if (rd_addr == PTR_RSTAT)  rd_data = radio_stat;
        else if (rd_addr == PTR_TPLO)   rd_data = tune_lo;
        else if (rd_addr == PTR_TPHI)   rd_data = tune_hi;
        else                            rd_data = 8'h00;
    end

    // Side-effect strobes toward the command logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            abort     <= 1'b0;
            clr_radio <= 1'b0;
            clr_cmd   <= 1'b0;
        end else begin
            abort     <= wr_en && (wr_addr == PTR_ID);
            clr_radio <= rd_done && (rd_addr == PTR_RSTAT);
            clr_cmd   <= rd_done && (rd_addr == PTR_TPHI);
        end
    end
endmodule

// File: rtl/i2c_rf_slave.sv
// Top of the I2C control-register target: filters, bus engine, register bank.
// Assumes an external open-drain pad: sda_oe_o high pulls SDA low.
module i2c_rf_slave
    import i2c_rf_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h60,
    parameter logic [7:0] ID_VALUE = 8'h12,
    parameter int         FILT_LEN = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [7:0]        radio_stat_i,
    input  logic [7:0]        tune_lo_i,
    input  logic [7:0]        tune_hi_i,
    output logic [CTRL_W-1:0] ctrl_regs_o,
    output logic              abort_o,
    output logic              clr_radio_irq_o,
    output logic              clr_cmd_end_o
);
    logic       scl_f, sda_f;
    logic       wr_en, rd_done, bus_skip;
    logic [7:0] wr_data, ptr, rd_data, wr_addr;

    assign wr_addr = ptr;

    i2c_rf_glitch #(.FILT_LEN(FILT_LEN)) u_flt_scl (
        .clk(clk), .rst_n(rst_n), .din(scl_i), .dout(scl_f)
    );
    i2c_rf_glitch #(.FILT_LEN(FILT_LEN)) u_flt_sda (
        .clk(clk), .rst_n(rst_n), .din(sda_i), .dout(sda_f)
    );

    i2c_rf_bus #(.DEV_ADDR(DEV_ADDR)) u_bus (
        .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
        .rd_data(rd_data), .sda_oe(sda_oe_o), .wr_en(wr_en),
        .wr_data(wr_data), .ptr(ptr), .rd_done(rd_done), .skip(bus_skip)
    );

    i2c_rf_regs #(.ID_VALUE(ID_VALUE)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(ptr), .rd_done(rd_done),
        .radio_stat(radio_stat_i), .tune_lo(tune_lo_i), .tune_hi(tune_hi_i),
        .ctrl(ctrl_regs_o), .rd_data(rd_data), .abort(abort_o),
        .clr_radio(clr_radio_irq_o), .clr_cmd(clr_cmd_end_o)
    );
endmodule

// File: rtl/i2c_rf_checker.sv
// Property checker for the I2C control-register target, bound to the top.
module i2c_rf_checker
    import i2c_rf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic [CTRL_W-1:0] ctrl,
    input logic              wr_en,
    input logic [7:0]        wr_addr,
    input logic              rd_done,
    input logic [7:0]        rd_addr,
    input logic              abort,
    input logic              clr_radio,
    input logic              clr_cmd,
    input logic              skip
);
    // R3: the bank only moves after a committed write
    p_ctrl_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl));

    // R6: writes to identifier and read-only pointers leave the bank alone
    p_ro_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == 8'h00 || wr_addr == 8'h02 ||
                   wr_addr == 8'h10 || wr_addr == 8'h11)) |=> $stable(ctrl));

    // R5: abort pulse comes from a write to pointer 00h and lasts one cycle
    p_abort_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> ($past(wr_en) && $past(wr_addr) == 8'h00));
    p_abort_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> !abort);

    // R7: clear strobes follow a finished read of their pointer, one cycle each
    p_clr_radio_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_radio |-> ($past(rd_done) && $past(rd_addr) == 8'h02));
    p_clr_cmd_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_cmd |-> ($past(rd_done) && $past(rd_addr) == 8'h11));
    p_clr_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_radio || clr_cmd) |=> !(clr_radio || clr_cmd));
    p_strobe_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({abort, clr_radio, clr_cmd}));

    // R9: SDA stays released while a foreign transfer is ignored
    p_skip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        skip |-> !sda_oe);
endmodule

bind i2c_rf_slave i2c_rf_checker u_chk (
    .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe_o), .ctrl(ctrl_regs_o),
    .wr_en(wr_en), .wr_addr(wr_addr), .rd_done(rd_done), .rd_addr(ptr),
    .abort(abort_o), .clr_radio(clr_radio_irq_o), .clr_cmd(clr_cmd_end_o),
    .skip(bus_skip)
);

// File: tb/i2c_rf_slave_tb.sv
`timescale 1ns/1ps
module i2c_rf_slave_tb;
    localparam int Q      = 14;
    localparam int NRW    = 10;
    localparam int CW     = NRW * 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          scl_m, sda_m, scl_glitch, sda_glitch;
    logic          sda_oe;
    logic [7:0]    stat_v, tlo_v, thi_v;
    logic [CW-1:0] ctrl;
    logic          abort_s, clr_r, clr_c;
    wire           sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_fail = 0;
    int n_abort = 0, n_clr_r = 0, n_clr_c = 0;
    bit cmp_en = 0;
    bit glitch_en = 0;
    byte unsigned model [256];
    byte unsigned rw_list [$] = '{8'h0B, 8'h0D, 8'h0E, 8'h0F, 8'h19,
                                   8'h1A, 8'h1B, 8'h1D, 8'h1E, 8'h1F};

    always #5 clk = ~clk;

    i2c_rf_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m & ~scl_glitch),
        .sda_i(sda_line & ~sda_glitch), .sda_oe_o(sda_oe),
        .radio_stat_i(stat_v), .tune_lo_i(tlo_v), .tune_hi_i(thi_v),
        .ctrl_regs_o(ctrl), .abort_o(abort_s),
        .clr_radio_irq_o(clr_r), .clr_cmd_end_o(clr_c)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic bit is_rw(input byte unsigned a);
        foreach (rw_list[i]) if (rw_list[i] == a) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [CW-1:0] model_ctrl();
        logic [CW-1:0] v;
        foreach (rw_list[i]) v[i*8 +: 8] = model[rw_list[i]];
        return v;
    endfunction

    function automatic int model_read(input byte unsigned a);
        if (a == 8'h00) return 8'h12;
        if (a == 8'h02) return stat_v;
        if (a == 8'h10) return tlo_v;
        if (a == 8'h11) return thi_v;
        if (is_rw(a))   return model[a];
        return 0;
    endfunction

    // Strobe counting and idle comparison against the model, away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (abort_s) n_abort++;
            if (clr_r)   n_clr_r++;
            if (clr_c)   n_clr_c++;
            if (cmp_en) begin
                chk("R3 bank vs model", (ctrl == model_ctrl()) ? 1 : 0, 1);
                chk("R9 SDA released when idle", sda_oe, 0);
            end
        end
    end

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic send_byte(input byte unsigned b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl_m = 1'b1; wq();
            if (glitch_en && i == 3) begin
                scl_glitch = 1'b1; repeat (2) @(negedge clk); scl_glitch = 1'b0;
                repeat (2) @(negedge clk);
                sda_glitch = 1'b1; repeat (2) @(negedge clk); sda_glitch = 1'b0;
            end
            wq(); scl_m = 1'b0; wq();
        end
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
        acked = ~sda_line;
        wq(); scl_m = 1'b0; wq();
    endtask

    task automatic recv_byte(output byte unsigned b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0;
        end
        wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic do_write(input byte unsigned a, input byte unsigned d, input int extra);
        bit ack;
        cmp_en = 0;
        bus_start();
        send_byte(8'hC0, ack); chk("R2 ack write address", ack, 1);
        send_byte(a, ack);     chk("R2 ack pointer", ack, 1);
        send_byte(d, ack);     chk("R2 ack data", ack, 1);
        for (int k = 0; k < extra; k++) begin
            send_byte(d ^ 8'h5A ^ 8'(k), ack); chk("R8 trailing byte acked", ack, 1);
        end
        bus_stop();
        if (is_rw(a)) model[a] = d;
        wq();
        cmp_en = 1;
    endtask

    task automatic do_read(input byte unsigned a, input bit via_stop, output byte unsigned d);
        bit ack;
        cmp_en = 0;
        bus_start();
        send_byte(8'hC0, ack); chk("R2 ack write address", ack, 1);
        send_byte(a, ack);     chk("R2 ack pointer", ack, 1);
        if (via_stop) begin bus_stop(); wq(); end
        bus_start();
        send_byte(8'hC1, ack); chk("R2 ack read address", ack, 1);
        recv_byte(d);
        bus_stop();
        wq();
        cmp_en = 1;
    endtask

    task automatic read_chk(input string req, input byte unsigned a, input bit via_stop);
        byte unsigned d;
        do_read(a, via_stop, d);
        chk(req, d, model_read(a));
    endtask

    // Watchdog: a hung run ends as a failure.
    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        byte unsigned d;
        bit ack;
        int a0, r0, c0;
        foreach (model[i]) model[i] = 8'h00;
        rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; scl_glitch = 1'b0; sda_glitch = 1'b0;
        stat_v = 8'h9B; tlo_v = 8'h3C; thi_v = 8'hE1;
        repeat (10) @(negedge clk);
        chk("R1 bank in reset", (ctrl == '0) ? 1 : 0, 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bank after reset", (ctrl == '0) ? 1 : 0, 1);
        chk("R1 SDA released", sda_oe, 0);
        chk("R1 strobes low", {abort_s, clr_r, clr_c}, 0);
        cmp_en = 1;

        // R3 / R4: every writable slot, distinct patterns, then read back
        foreach (rw_list[i]) do_write(rw_list[i], 8'(8'hA5 ^ (i * 37)), 0);
        foreach (rw_list[i]) read_chk("R4 readback", rw_list[i], 0);
        do_write(8'h1E, 8'h80, 0); read_chk("R4 MSB only", 8'h1E, 0);
        do_write(8'h1E, 8'h01, 0); read_chk("R4 LSB only", 8'h1E, 0);

        // R5: identifier and abort strobe
        read_chk("R5 identifier", 8'h00, 0);
        a0 = n_abort;
        do_write(8'h00, 8'h77, 0);
        chk("R5 one abort pulse", n_abort - a0, 1);
        read_chk("R5 identifier after write", 8'h00, 0);

        // R6: read-only pointers follow inputs, writes ignored
        read_chk("R6 status", 8'h02, 0);
        read_chk("R6 tune low", 8'h10, 0);
        do_write(8'h02, 8'h00, 0); do_write(8'h10, 8'hFF, 0); do_write(8'h11, 8'h00, 0);
        stat_v = 8'h41; tlo_v = 8'hC2; thi_v = 8'h18;
        read_chk("R6 status after write", 8'h02, 0);
        read_chk("R6 tune high after write", 8'h11, 0);

        // R7: clear-on-read strobes
        r0 = n_clr_r; c0 = n_clr_c;
        read_chk("R7 status read", 8'h02, 0);
        chk("R7 radio clear once", n_clr_r - r0, 1);
        chk("R7 no cmd clear on 02h", n_clr_c - c0, 0);
        r0 = n_clr_r; c0 = n_clr_c;
        read_chk("R7 tune high read", 8'h11, 0);
        chk("R7 cmd clear once", n_clr_c - c0, 1);
        chk("R7 no radio clear on 11h", n_clr_r - r0, 0);
        r0 = n_clr_r; c0 = n_clr_c;
        read_chk("R7 other read", 8'h10, 0);
        read_chk("R7 other read", 8'h0D, 0);
        chk("R7 no strobes on other reads", (n_clr_r - r0) + (n_clr_c - c0), 0);

        // R8: only the first data byte lands, no auto-increment
        do_write(8'h0E, 8'h3D, 3);
        read_chk("R8 first byte kept", 8'h0E, 0);
        read_chk("R8 next pointer untouched", 8'h0F, 0);

        // R9: foreign address gets no ACK and changes nothing
        cmp_en = 0;
        bus_start();
        send_byte(8'hA0, ack); chk("R9 no ack for foreign address", ack, 0);
        send_byte(8'h0D, ack); chk("R9 no ack after foreign address", ack, 0);
        send_byte(8'h66, ack); chk("R9 no ack on data", ack, 0);
        bus_stop(); wq(); cmp_en = 1;
        read_chk("R9 register unchanged", 8'h0D, 0);

        // R10: unmapped pointers
        do_write(8'h05, 8'h77, 0);
        read_chk("R10 unmapped reads zero", 8'h05, 0);
        read_chk("R10 unmapped reads zero", 8'h30, 0);

        // R11: stop-then-start turnaround keeps the pointer
        do_write(8'h1A, 8'hC6, 0);
        read_chk("R11 stop+start read", 8'h1A, 1);
        read_chk("R11 repeated start read", 8'h1A, 0);

        // R12: short glitches on both lines mid-byte
        glitch_en = 1;
        do_write(8'h1B, 8'h5E, 0);
        glitch_en = 0;
        read_chk("R12 write survives glitches", 8'h1B, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule